// File: doc/BRIEF.md
# Address Translation Cache with Table Walk

This block turns a logical address from a processor port into a physical address. The logical address is split into two fields. The low `OFF_W` bits are the in-page offset and pass through unchanged. The upper `VA_W-OFF_W` bits are the virtual page number. A small fully associative store holds recent page-to-frame pairs. When the page is present, the translation comes back on the cycle after acceptance and memory is not touched.

When the page is absent, the block reads one table entry from memory. The read address is the table base register plus the page number. If the entry is marked present, the block writes it into the store and returns the translation. If it is not present, the block reports a fault instead.

A request can ask for its fill to be pinned. Pinned entries are never chosen as replacement victims, and they survive a flush. A flush input empties every unpinned entry in a single cycle.

Top module: `xlat_cache`

## Requirements
- R1: `resp_paddr` equals the frame number in its upper `PFN_W` bits, with the request's low `OFF_W` offset bits copied unchanged below it.
- R2: A request accepted while its page is held in the store returns `resp_valid` with `resp_hit`=1 exactly one cycle later, and `mem_valid` stays low.
- R3: On a miss, `mem_valid` rises the cycle after acceptance with `mem_addr` = base + page number (modulo 2^`MA_W`). Both hold steady until a cycle with `mem_ready` high.
- R4: `mem_rdata` bit `PFN_W` is the present flag and bits `PFN_W-1:0` are the frame. When the flag is set, the response arrives the cycle after the `mem_ready` cycle with `resp_hit`=0, and a later request to the same page hits.
- R5: A table entry with the present flag clear gives `resp_fault`=1 with `resp_paddr`=0 and no fill, so the same page misses again.
- R6: The victim is the first unpinned entry found by scanning cyclically from a rotating pointer. The pointer starts at entry 0 after reset and moves to the slot after each victim.
- R7: Pinned entries (filled with `req_wire`=1) are never replaced. When every entry is pinned, the fill is skipped but the translation is still returned.
- R8: `flush` clears all unpinned entries in one cycle and keeps pinned ones. A fill landing in the same cycle as a flush survives, and a lookup in the flush cycle still sees the old contents.
- R9: `base_we` loads the base register only while no walk is in progress. A walk started in the same cycle already uses the new value, and a write during a walk is ignored.
- R10: After reset `req_ready`=1, `resp_valid`=0 and `mem_valid`=0. `req_ready` stays low for the whole walk, so requests are not taken then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | VA_W | Logical address |
| req_wire | input | 1 | Pin the entry filled by this request |
| req_ready | output | 1 | Block idle, request taken when valid |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_paddr | output | PFN_W+OFF_W | Physical address |
| resp_hit | output | 1 | Response came from the store |
| resp_fault | output | 1 | Table entry not present |
| base_we | input | 1 | Table base write strobe |
| base_wdata | input | MA_W | New table base |
| flush | input | 1 | Invalidate unpinned entries |
| mem_valid | output | 1 | Table read request |
| mem_addr | output | MA_W | Table read address |
| mem_ready | input | 1 | Read accepted, `mem_rdata` valid this cycle |
| mem_rdata | input | PFN_W+1 | Table entry: present flag over frame |

## Verification
The collision that matters most is a flush that coincides with a walk's fill. Both then write the valid bits in the same cycle. The bench holds `flush` high for every cycle of a walk, including the `mem_ready` cycle, and then re-requests that page. It expects a hit, while earlier unpinned pages must miss. The bench also asserts `flush` during a hitting lookup and expects the hit to be reported. A behavioural model runs alongside and is compared every clock, including in a random phase where flushes and memory latencies vary.

// File: rtl/xlat_pkg.sv
`timescale 1ns/1ps
package xlat_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WALK = 1'b1
  } walk_st_t;
endpackage

// File: rtl/xlat_entries.sv
`timescale 1ns/1ps
module xlat_entries #(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 8,
  parameter int PFN_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [VPN_W-1:0]           lk_vpn,
  output logic                       lk_hit,
  output logic [PFN_W-1:0]           lk_pfn,
  input  logic                       flush,
  input  logic                       fill_en,
  input  logic [$clog2(ENTRIES)-1:0] fill_idx,
  input  logic [VPN_W-1:0]           fill_vpn,
  input  logic [PFN_W-1:0]           fill_pfn,
  input  logic                       fill_wired,
  output logic [ENTRIES-1:0]         wired_vec
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] vld_q, vld_d, wir_q, wir_d, match;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PFN_W-1:0]   pfn_q [ENTRIES];

  // tag compare per slot
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (tag_q[g] == lk_vpn);
  end

  always_comb begin
    lk_pfn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) lk_pfn = lk_pfn | pfn_q[i];
    end
  end
  assign lk_hit    = |match;
  assign wired_vec = wir_q;

  // flush first, fill on top so a same-cycle fill survives
  always_comb begin
    vld_d = vld_q;
    wir_d = wir_q;
    if (flush) vld_d = vld_q & wir_q;
    if (fill_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (fill_idx == IDX_W'(i)) begin
          vld_d[i] = 1'b1;
          wir_d[i] = fill_wired;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      wir_q <= '0;
    end else begin
      vld_q <= vld_d;
      wir_q <= wir_d;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_data
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q[g] <= '0;
        pfn_q[g] <= '0;
      end else if (fill_en && (fill_idx == IDX_W'(g))) begin
        tag_q[g] <= fill_vpn;
        pfn_q[g] <= fill_pfn;
      end
    end
  end

  a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
  a_r7_fill_not_wired: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> !wir_q[fill_idx]);
  a_r8_flush_keeps_wired: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !fill_en) |=> (vld_q == $past(vld_q & wir_q)));
endmodule

// File: rtl/xlat_victim.sv
`timescale 1ns/1ps
module xlat_victim #(
  parameter int ENTRIES = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ENTRIES-1:0]         wired_vec,
  input  logic                       adv,
  output logic [$clog2(ENTRIES)-1:0] victim_idx,
  output logic                       victim_ok
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [IDX_W-1:0] ptr_q, ptr_d;

  // cyclic scan from the pointer for the first unpinned slot
  always_comb begin
    victim_ok  = 1'b0;
    victim_idx = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      int ix;
      ix = (int'(ptr_q) + k) % ENTRIES;
      if (!victim_ok && !wired_vec[ix]) begin
        victim_ok  = 1'b1;
        victim_idx = IDX_W'(ix);
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (adv && victim_ok) begin
      ptr_d = (victim_idx == IDX_W'(ENTRIES - 1)) ? '0 : victim_idx + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  a_r6_victim_unpinned: assert property (@(posedge clk) disable iff (!rst_n)
    victim_ok |-> !wired_vec[victim_idx]);
  a_r7_none_when_all_pinned: assert property (@(posedge clk) disable iff (!rst_n)
    !victim_ok |-> (&wired_vec));
endmodule

// File: rtl/xlat_walker.sv
`timescale 1ns/1ps
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int VPN_W = 8,
  parameter int OFF_W = 8,
  parameter int PFN_W = 8,
  parameter int MA_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [VPN_W-1:0]       req_vpn,
  input  logic [OFF_W-1:0]       req_off,
  input  logic                   req_wire,
  output logic                   req_ready,
  input  logic                   lk_hit,
  input  logic [PFN_W-1:0]       lk_pfn,
  input  logic                   base_we,
  input  logic [MA_W-1:0]        base_wdata,
  output logic                   mem_valid,
  output logic [MA_W-1:0]        mem_addr,
  input  logic                   mem_ready,
  input  logic [PFN_W:0]         mem_rdata,
  input  logic                   victim_ok,
  output logic                   fill_en,
  output logic [VPN_W-1:0]       fill_vpn,
  output logic [PFN_W-1:0]       fill_pfn,
  output logic                   fill_wired,
  output logic                   resp_valid,
  output logic [PFN_W+OFF_W-1:0] resp_paddr,
  output logic                   resp_hit,
  output logic                   resp_fault
);
  localparam int PA_W = PFN_W + OFF_W;

  walk_st_t         st_q, st_d;
  logic [VPN_W-1:0] vpn_q;
  logic [OFF_W-1:0] off_q;
  logic             wire_q;
  logic [MA_W-1:0]  base_q;
  logic             rv_q, rv_d, hit_q, hit_d, flt_q, flt_d;
  logic [PA_W-1:0]  pa_q, pa_d;
  logic             accept, mem_done, pte_ok, base_en;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign mem_valid = (st_q == ST_WALK);
  assign mem_addr  = base_q + MA_W'(vpn_q);
  assign mem_done  = mem_valid && mem_ready;
  assign pte_ok    = mem_rdata[PFN_W];
  assign base_en   = base_we && (st_q == ST_IDLE);

  assign fill_en    = mem_done && pte_ok && victim_ok;
  assign fill_vpn   = vpn_q;
  assign fill_pfn   = mem_rdata[PFN_W-1:0];
  assign fill_wired = wire_q;

  always_comb begin
    st_d  = st_q;
    rv_d  = 1'b0;
    pa_d  = pa_q;
    hit_d = hit_q;
    flt_d = flt_q;
    if (accept) begin
      if (lk_hit) begin
        rv_d  = 1'b1;
        pa_d  = {lk_pfn, req_off};
        hit_d = 1'b1;
        flt_d = 1'b0;
      end else begin
        st_d = ST_WALK;
      end
    end
    if (mem_done) begin
      st_d  = ST_IDLE;
      rv_d  = 1'b1;
      hit_d = 1'b0;
      flt_d = !pte_ok;
      pa_d  = pte_ok ? {mem_rdata[PFN_W-1:0], off_q} : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      rv_q <= 1'b0;
    end else begin
      st_q <= st_d;
      rv_q <= rv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpn_q  <= '0;
      off_q  <= '0;
      wire_q <= 1'b0;
    end else if (accept) begin
      vpn_q  <= req_vpn;
      off_q  <= req_off;
      wire_q <= req_wire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_en) base_q <= base_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q  <= '0;
      hit_q <= 1'b0;
      flt_q <= 1'b0;
    end else if (rv_d) begin
      pa_q  <= pa_d;
      hit_q <= hit_d;
      flt_q <= flt_d;
    end
  end

  assign resp_valid = rv_q;
  assign resp_paddr = pa_q;
  assign resp_hit   = hit_q;
  assign resp_fault = flt_q;

  a_r3_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)));
  a_r10_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready);
  a_r9_base_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WALK) |=> (base_q == $past(base_q)));
  a_r5_fault_excl_hit: assert property (@(posedge clk) disable iff (!rst_n)
    resp_fault |-> (!resp_hit && (resp_paddr == '0)));
endmodule

// File: rtl/xlat_cache.sv
`timescale 1ns/1ps
module xlat_cache #(
  parameter int VA_W    = 16,
  parameter int OFF_W   = 8,
  parameter int PFN_W   = 8,
  parameter int MA_W    = 16,
  parameter int ENTRIES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [VA_W-1:0]        req_vaddr,
  input  logic                   req_wire,
  output logic                   req_ready,
  output logic                   resp_valid,
  output logic [PFN_W+OFF_W-1:0] resp_paddr,
  output logic                   resp_hit,
  output logic                   resp_fault,
  input  logic                   base_we,
  input  logic [MA_W-1:0]        base_wdata,
  input  logic                   flush,
  output logic                   mem_valid,
  output logic [MA_W-1:0]        mem_addr,
  input  logic                   mem_ready,
  input  logic [PFN_W:0]         mem_rdata
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int IDX_W = $clog2(ENTRIES);

  logic [VPN_W-1:0]   req_vpn, fill_vpn;
  logic [OFF_W-1:0]   req_off;
  logic               lk_hit, fill_en, fill_wired, victim_ok;
  logic [PFN_W-1:0]   lk_pfn, fill_pfn;
  logic [IDX_W-1:0]   victim_idx;
  logic [ENTRIES-1:0] wired_vec;

  assign req_vpn = req_vaddr[VA_W-1:OFF_W];
  assign req_off = req_vaddr[OFF_W-1:0];

  xlat_entries #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_entries (
    .clk(clk), .rst_n(rst_n),
    .lk_vpn(req_vpn), .lk_hit(lk_hit), .lk_pfn(lk_pfn),
    .flush(flush),
    .fill_en(fill_en), .fill_idx(victim_idx), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .fill_wired(fill_wired),
    .wired_vec(wired_vec)
  );

  xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n),
    .wired_vec(wired_vec), .adv(fill_en),
    .victim_idx(victim_idx), .victim_ok(victim_ok)
  );

  xlat_walker #(.VPN_W(VPN_W), .OFF_W(OFF_W), .PFN_W(PFN_W), .MA_W(MA_W)) u_walker (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vpn(req_vpn), .req_off(req_off),
    .req_wire(req_wire), .req_ready(req_ready),
    .lk_hit(lk_hit), .lk_pfn(lk_pfn),
    .base_we(base_we), .base_wdata(base_wdata),
    .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .victim_ok(victim_ok),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_wired(fill_wired),
    .resp_valid(resp_valid), .resp_paddr(resp_paddr),
    .resp_hit(resp_hit), .resp_fault(resp_fault)
  );

  a_r2_hit_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_hit) |-> $past(!mem_valid));
  a_r1_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_hit) |-> (resp_paddr[OFF_W-1:0] == $past(req_off)));
endmodule

// File: tb/xlat_cache_bench.sv
`timescale 1ns/1ps
module xlat_cache_bench;
  localparam int E = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_wire = 1'b0, base_we = 1'b0, flush = 1'b0;
  logic        mem_ready = 1'b0;
  logic [15:0] req_vaddr = '0, base_wdata = '0;
  logic        req_ready, resp_valid, resp_hit, resp_fault, mem_valid;
  logic [15:0] resp_paddr, mem_addr;
  logic [8:0]  mem_rdata;

  int n_chk = 0, n_fail = 0;
  string cur = "R10";

  // behavioural model state
  bit m_vld[E], m_wir[E];
  int m_tag[E], m_pfn[E];
  int m_ptr, m_base, m_vpn, m_off, m_wait, lat;
  bit m_walk, m_wire;
  bit e_rv, e_hit, e_flt;
  int e_pa;

  function automatic int pte_of(int a);
    int ok;
    ok = ((a & 15) != 15) ? 1 : 0;
    return (ok << 8) | (((a * 37) + 11) & 255);
  endfunction

  assign mem_rdata = 9'(pte_of(int'(mem_addr)));

  always #2.5 clk = ~clk;

  xlat_cache u_xlat_cache (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_wire(req_wire),
    .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_paddr(resp_paddr),
    .resp_hit(resp_hit), .resp_fault(resp_fault),
    .base_we(base_we), .base_wdata(base_wdata), .flush(flush),
    .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < E; i++) begin
      m_vld[i] = 0; m_wir[i] = 0; m_tag[i] = 0; m_pfn[i] = 0;
    end
    m_ptr = 0; m_base = 0; m_walk = 0; m_wait = 0; m_vpn = 0; m_off = 0; m_wire = 0;
  endtask

  // one clock: predict, advance, compare
  task automatic step();
    int hi, fi, pte, vpn;
    bit gw, ew;
    hi = -1; fi = -1; gw = 0; ew = 0; e_rv = 0;
    vpn = int'(req_vaddr) >> 8;
    if (!m_walk) begin
      if (req_valid) begin
        for (int i = 0; i < E; i++) if (m_vld[i] && m_tag[i] == vpn) hi = i;
        if (hi >= 0) begin
          e_rv = 1; e_hit = 1; e_flt = 0;
          e_pa = (m_pfn[hi] << 8) | (int'(req_vaddr) & 255);
        end else gw = 1;
      end
    end else if (mem_ready) begin
      pte = pte_of((m_base + m_vpn) & 16'hFFFF);
      ew = 1; e_rv = 1; e_hit = 0;
      if (pte[8]) begin
        e_flt = 0; e_pa = ((pte & 255) << 8) | m_off;
        for (int k = 0; k < E; k++) begin
          int ix;
          ix = (m_ptr + k) % E;
          if (fi < 0 && !m_wir[ix]) fi = ix;
        end
      end else begin
        e_flt = 1; e_pa = 0;
      end
    end
    if (flush) for (int i = 0; i < E; i++) if (!m_wir[i]) m_vld[i] = 0;
    if (fi >= 0) begin
      m_vld[fi] = 1; m_wir[fi] = m_wire; m_tag[fi] = m_vpn; m_pfn[fi] = pte & 255;
      m_ptr = (fi + 1) % E;
    end
    if (!m_walk && base_we) m_base = int'(base_wdata);
    if (gw) begin
      m_walk = 1; m_vpn = vpn; m_off = int'(req_vaddr) & 255; m_wire = req_wire; m_wait = 0;
    end
    if (ew) m_walk = 0;
    @(posedge clk);
    #1;
    chk(cur, "req_ready", int'(req_ready), int'(!m_walk));
    chk(cur, "mem_valid", int'(mem_valid), int'(m_walk));
    if (m_walk) chk(cur, "mem_addr", int'(mem_addr), (m_base + m_vpn) & 16'hFFFF);
    chk(cur, "resp_valid", int'(resp_valid), int'(e_rv));
    if (e_rv) begin
      chk(cur, "resp_paddr", int'(resp_paddr), e_pa);
      chk(cur, "resp_hit", int'(resp_hit), int'(e_hit));
      chk(cur, "resp_fault", int'(resp_fault), int'(e_flt));
    end
    mem_ready = m_walk && (m_wait >= lat);
    if (m_walk) m_wait++;
  endtask

  task automatic run_req(int va, bit w);
    req_vaddr = 16'(va); req_wire = w; req_valid = 1'b1;
    step();
    req_valid = 1'b0; req_wire = 1'b0;
    while (m_walk) step();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req_valid = 0; flush = 0; base_we = 0; mem_ready = 0;
    model_reset();
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    chk("R10", "req_ready after reset", int'(req_ready), 1);
    chk("R10", "resp_valid after reset", int'(resp_valid), 0);
    chk("R10", "mem_valid after reset", int'(mem_valid), 0);
  endtask

  task automatic set_base(int b);
    base_wdata = 16'(b); base_we = 1'b1; step(); base_we = 1'b0;
  endtask

  initial begin
    #(5 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    lat = 0;
    do_reset();
    cur = "R9"; set_base(16'h1000);
    cur = "R3"; run_req(16'h1234, 0);
    chk("R1", "miss paddr", int'(resp_paddr), (((16'h1012 * 37) + 11) & 255) << 8 | 16'h34);
    cur = "R4"; run_req(16'h12A7, 0);
    chk("R4", "refill hit", int'(resp_hit), 1);
    chk("R1", "hit offset", int'(resp_paddr) & 255, 16'hA7);

    // R6 rotation: after a flush, four fills then a fifth evicts the first
    cur = "R6"; lat = 2; flush = 1; step(); flush = 0;
    for (int p = 0; p < 5; p++) run_req((16'h20 + p) << 8, 0);
    run_req(16'h2100, 0); chk("R6", "second page kept", int'(resp_hit), 1);
    run_req(16'h2000, 0); chk("R6", "first page evicted", int'(resp_hit), 0);

    // R5 fault: page 0x0F with base 0x1000 reads a non-present entry
    cur = "R5"; run_req(16'h0F10, 0);
    chk("R5", "fault flag", int'(resp_fault), 1);
    run_req(16'h0F10, 0); chk("R5", "fault not cached", int'(resp_hit), 0);

    // R9: base write during a walk is ignored
    cur = "R9"; lat = 3;
    req_vaddr = 16'h3100; req_valid = 1; step(); req_valid = 0;
    base_wdata = 16'h2000; base_we = 1;
    chk("R9", "walk address", int'(mem_addr), 16'h1031);
    while (m_walk) step();
    base_we = 0;
    run_req(16'h3200, 0); chk("R9", "base unchanged", int'(mem_addr), 16'h1032);

    // R8: flush held through a whole walk, fill survives
    cur = "R8"; lat = 1; flush = 1; run_req(16'h4400, 0); flush = 0;
    run_req(16'h4401, 0); chk("R8", "fill beats flush", int'(resp_hit), 1);
    run_req(16'h3200, 0); chk("R8", "old entry flushed", int'(resp_hit), 0);
    flush = 1; run_req(16'h3205, 0); flush = 0;
    chk("R8", "lookup in flush cycle", int'(resp_hit), 1);

    // R7: pinned entries
    cur = "R7"; lat = 0; flush = 1; step(); flush = 0;
    for (int p = 0; p < 3; p++) run_req((16'h50 + p) << 8, 1);
    run_req(16'h6000, 0); run_req(16'h6100, 0);
    run_req(16'h6000, 0); chk("R7", "shared slot evicted", int'(resp_hit), 0);
    flush = 1; step(); flush = 0;
    for (int p = 0; p < 3; p++) begin
      run_req(((16'h50 + p) << 8) | 16'h0C, 0);
      chk("R7", "pinned survives", int'(resp_hit), 1);
    end
    run_req(16'h5300, 1);
    run_req(16'h7000, 0); chk("R7", "all pinned translation", int'(resp_valid), 1);
    run_req(16'h7000, 0); chk("R7", "all pinned no fill", int'(resp_hit), 0);

    // random phase against the model
    do_reset();
    cur = "R4"; set_base(16'h0800);
    for (int n = 0; n < 300; n++) begin
      lat = $urandom_range(0, 3);
      flush = ($urandom_range(0, 9) == 0);
      run_req(($urandom_range(0, 9) << 8) | $urandom_range(0, 255), 0);
      flush = 0;
      if ($urandom_range(0, 3) == 0) step();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule